// File: doc/BRIEF.md
# Shadow-Committed PWM Generator with Dead Band

This block makes a pulse-width-modulated waveform from an 8-bit period timer. The timer is extended below by a 2-bit sub-cycle count, and a prescaler of 1, 4 or 16 clocks sets the rate of the combined count. Software writes four registers: period, upper duty, control and a combined prescale/delay register. The writes land in holding copies. They reach the working copies only at a boundary of the waveform, so a write made in the middle of a period never cuts a pulse short or stretches it.

The primary waveform can be sent to up to four outputs. The complement of the primary can also be sent, and it is held off for a programmable number of clocks after each falling edge of the primary, which gives a dead band. Each output pair has its own polarity. A one-clock strobe marks the start of every period.

Top module: `epwm_top`

## Requirements
- R1: One period lasts (period + 1) × 4 × prescale clocks. `period_tick` is high for exactly one clock, in the first clock of each new period.
- R2: The prescale field is bits [7:6] of register 3. The value 00 selects 1, the value 01 selects 4, and 10 or 11 select 16.
- R3: The duty value is 10 bits wide: register 1 is the upper 8 bits and control bits [5:4] are the lower 2. The primary is active while {timer, sub-count} is less than the duty value. A duty of 0 never drives it active. A duty above the last count keeps it active for the whole period.
- R4: Writes to register 0 (period), register 1, register 2 (control) and the prescale field take effect only at the next period boundary. A write made in the same clock as the boundary waits for the following boundary.
- R5: A write to the delay field (bits [5:0] of register 3) commits at the first falling edge of the primary or at the first period boundary after the write, whichever comes first. If it commits on a falling edge, that same edge already uses the new delay.
- R6: The complement is never active while the primary is active. After a falling edge of the primary, the complement is held inactive for the delay count in clocks, counted from the first clock in which the primary is low.
- R7: Control bits [7:6] steer the outputs. The bit order of `pwm_out` is {D, C, B, A}. 00 sends the primary to A only. 01 sends the primary to A and the complement to B. 10 sends the primary to A and C and the complement to B and D. 11 sends the primary to all four outputs. Outputs that carry no signal stay at their inactive level.
- R8: Control bit 1 inverts A and C, and control bit 0 inverts B and D. Polarity changes are committed at the period boundary, like the other control bits.
- R9: The generator runs only when control bits [3:2] are 11. It starts at a period boundary and not at the time of the write. When it is not running, every output sits at its inactive level.
- R10: After reset, `pwm_out` is 0 and `period_tick` is 0. The timer then runs with period 0 and prescale 1, and the generator is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 upper duty, 2 control, 3 prescale/delay |
| wr_data | input | 8 | Write data |
| pwm_out | output | 4 | Outputs {D, C, B, A} after polarity |
| period_tick | output | 1 | One-clock strobe at the start of each period |

## Verification
`pwm_out` and `period_tick` are registered. Each shows, one clock later, the counter state and working registers that were present at a rising edge. A write sampled at one edge therefore shows at the outputs only after the boundary that commits it, plus that one register stage. The bench's reference model takes each edge's inputs and predicts the outputs for the following clock. The outputs are compared at the falling edge, and the strobe spacing is measured separately in whole clocks.

// File: rtl/epwm_pkg.sv
package epwm_pkg;

  typedef enum logic [1:0] {
    OM_SINGLE   = 2'b00,
    OM_HALF     = 2'b01,
    OM_DUAL     = 2'b10,
    OM_PARALLEL = 2'b11
  } omode_e;

  typedef struct packed {
    omode_e     omode;
    logic [1:0] duty_lo;
    logic [1:0] run;
    logic       inv_ac;
    logic       inv_bd;
  } ctrl_t;

  function automatic logic [4:0] prescale_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // returns {D, C, B, A}
  function automatic logic [3:0] route_outputs(input omode_e m, input logic pri,
                                               input logic comp);
    case (m)
      OM_SINGLE: return {3'b000, pri};
      OM_HALF:   return {2'b00, comp, pri};
      OM_DUAL:   return {comp, pri, comp, pri};
      default:   return {4{pri}};
    endcase
  endfunction

  function automatic logic [3:0] polarity_mask(input ctrl_t c);
    return {c.inv_bd, c.inv_ac, c.inv_bd, c.inv_ac};
  endfunction

endpackage

// File: rtl/epwm_regs.sv
module epwm_regs
  import epwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             wrap,
  input  logic             fall,
  output logic [TMR_W-1:0] per_a,
  output logic [TMR_W+1:0] duty_a,
  output ctrl_t            ctrl_a,
  output logic [1:0]       pre_a,
  output logic [DLY_W-1:0] del_eff
);
  localparam logic [1:0] A_PER  = 2'd0;
  localparam logic [1:0] A_DUTY = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_MISC = 2'd3;

  logic [TMR_W-1:0] per_s, dhi_s, dhi_a;
  ctrl_t            ctrl_s;
  logic [1:0]       pre_s;
  logic [DLY_W-1:0] del_s, del_a;
  logic             del_pend, del_commit;

  assign del_commit = del_pend && (wrap || fall);
  assign del_eff    = del_commit ? del_s : del_a;
  assign duty_a     = {dhi_a, ctrl_a.duty_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_s <= '0; dhi_s <= '0; ctrl_s <= '0; pre_s <= '0; del_s <= '0;
      per_a <= '0; dhi_a <= '0; ctrl_a <= '0; pre_a <= '0; del_a <= '0;
      del_pend <= 1'b0;
    end else begin
      if (wrap) begin
        per_a  <= per_s;
        dhi_a  <= dhi_s;
        ctrl_a <= ctrl_s;
        pre_a  <= pre_s;
      end
      if (del_commit) del_a <= del_s;
      if (wr_en && wr_addr == A_MISC) del_pend <= 1'b1;
      else if (del_commit)            del_pend <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          A_PER:  per_s  <= wr_data;
          A_DUTY: dhi_s  <= wr_data;
          A_CTRL: ctrl_s <= ctrl_t'(wr_data[7:0]);
          default: begin
            pre_s <= wr_data[7:6];
            del_s <= wr_data[DLY_W-1:0];
          end
        endcase
      end
    end
  end

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(per_a) && $stable(duty_a) && $stable(ctrl_a) && $stable(pre_a)));

  assert_delay_commit_point_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap || fall) |=> $stable(del_a));

endmodule

// File: rtl/epwm_timebase.sv
module epwm_timebase
  import epwm_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] per_a,
  input  logic [1:0]       pre_a,
  output logic [TMR_W+1:0] cnt,
  output logic             wrap,
  output logic             period_tick
);
  localparam int CNT_W = TMR_W + 2;

  logic [3:0] pcnt;
  logic [4:0] plen;
  logic       step;

  assign plen = prescale_len(pre_a);
  assign step = ({1'b0, pcnt} == plen - 5'd1);
  assign wrap = step && (cnt == {per_a, 2'b11});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt        <= '0;
      cnt         <= '0;
      period_tick <= 1'b0;
    end else begin
      period_tick <= wrap;
      pcnt        <= step ? 4'd0 : pcnt + 4'd1;
      if (wrap)      cnt <= '0;
      else if (step) cnt <= cnt + CNT_W'(1);
    end
  end

  assert_wrap_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0 && period_tick));

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {per_a, 2'b11});

endmodule

// File: rtl/epwm_deadband.sv
module epwm_deadband #(
  parameter int TMR_W = 8,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [TMR_W+1:0] cnt,
  input  logic [TMR_W+1:0] duty_a,
  input  logic [DLY_W-1:0] del_eff,
  output logic             pri,
  output logic             comp,
  output logic             fall
);
  logic             pri_q;
  logic [DLY_W-1:0] dcnt;

  assign pri  = run_en && (cnt < duty_a);
  assign fall = pri_q && !pri;
  assign comp = run_en && !pri &&
                (fall ? (del_eff == '0) : (dcnt <= DLY_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= 1'b0;
      dcnt  <= '0;
    end else begin
      pri_q <= pri;
      if (fall)             dcnt <= del_eff;
      else if (dcnt != '0)  dcnt <= dcnt - DLY_W'(1);
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri && comp));

  assert_dead_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && del_eff > DLY_W'(1)) |=> !comp);

  assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_a == '0) |-> !pri);

endmodule

// File: rtl/epwm_steer.sv
module epwm_steer
  import epwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_t      ctrl_a,
  input  logic       run_en,
  input  logic       pri,
  input  logic       comp,
  output logic [3:0] pwm_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= '0;
    else        pwm_out <= route_outputs(ctrl_a.omode, pri, comp) ^ polarity_mask(ctrl_a);
  end

  assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pwm_out == $past(polarity_mask(ctrl_a))));

endmodule

// File: rtl/epwm_top.sv
module epwm_top
  import epwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic [3:0]       pwm_out,
  output logic             period_tick
);
  logic [TMR_W-1:0] per_a;
  logic [TMR_W+1:0] duty_a, cnt;
  ctrl_t            ctrl_a;
  logic [1:0]       pre_a;
  logic [DLY_W-1:0] del_eff;
  logic             wrap, fall, pri, comp, run_en;

  assign run_en = (ctrl_a.run == 2'b11);

  epwm_regs #(.TMR_W(TMR_W), .DLY_W(DLY_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wrap, .fall,
    .per_a, .duty_a, .ctrl_a, .pre_a, .del_eff
  );

  epwm_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk, .rst_n, .per_a, .pre_a, .cnt, .wrap, .period_tick
  );

  epwm_deadband #(.TMR_W(TMR_W), .DLY_W(DLY_W)) u_db (
    .clk, .rst_n, .run_en, .cnt, .duty_a, .del_eff, .pri, .comp, .fall
  );

  epwm_steer u_steer (
    .clk, .rst_n, .ctrl_a, .run_en, .pri, .comp, .pwm_out
  );

endmodule

// File: tb/tb_epwm_top.sv
module tb_epwm_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] pwm_out;
  logic       period_tick;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_req = "R10";

  epwm_top dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pwm_out, .period_tick);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int pos, since, dfall;
  int s_per, s_dhi, s_ctrl, s_pre, s_del, pend;
  int a_per, a_dhi, a_ctrl, a_pre, a_del;
  bit lastpri;
  logic [3:0] exp_out = '0;
  logic       exp_tick = 1'b0;

  function automatic int div_of(int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; since = 100000; dfall = 0; lastpri = 0;
      s_per = 0; s_dhi = 0; s_ctrl = 0; s_pre = 0; s_del = 0; pend = 0;
      a_per = 0; a_dhi = 0; a_ctrl = 0; a_pre = 0; a_del = 0;
      exp_out = '0; exp_tick = 1'b0;
    end else begin
      int dv, plen, duty, mode;
      bit en, pri, fall, wrap, dcommit, comp;
      logic [3:0] r, pol;
      dv   = div_of(a_pre);
      plen = (a_per + 1) * 4 * dv;
      en   = ((a_ctrl >> 2) & 3) == 3;
      duty = a_dhi * 4 + ((a_ctrl >> 4) & 3);
      pri  = en && (pos / dv) < duty;
      fall = lastpri && !pri;
      wrap = (pos == plen - 1);
      dcommit = pend != 0 && (wrap || fall);
      if (fall) begin
        since = 0;
        dfall = dcommit ? s_del : a_del;
      end else if (since < 100000) since++;
      comp = en && !pri && since >= dfall;
      mode = (a_ctrl >> 6) & 3;
      if (mode == 0)      r = {3'b000, pri};
      else if (mode == 1) r = {2'b00, comp, pri};
      else if (mode == 2) r = {comp, pri, comp, pri};
      else                r = {4{pri}};
      pol = {a_ctrl[0], a_ctrl[1], a_ctrl[0], a_ctrl[1]};
      exp_out  = r ^ pol;
      exp_tick = wrap;
      lastpri  = pri;
      if (wrap) begin
        pos = 0; a_per = s_per; a_dhi = s_dhi; a_ctrl = s_ctrl; a_pre = s_pre;
      end else pos++;
      if (dcommit) begin a_del = s_del; pend = 0; end
      if (wr_en) begin
        case (wr_addr)
          2'd0: s_per  = wr_data;
          2'd1: s_dhi  = wr_data;
          2'd2: s_ctrl = wr_data;
          default: begin s_pre = wr_data[7:6]; s_del = wr_data[5:0]; pend = 1; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_checks++;
      if (pwm_out !== exp_out || period_tick !== exp_tick) begin
        n_fail++;
        $display("FAIL %s: cycle %0d out=%b tick=%b expected out=%b tick=%b",
                 cur_req, cycles, pwm_out, period_tick, exp_out, exp_tick);
      end
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion before 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int expv, input string req);
    int n;
    n = 0;
    while (period_tick !== 1'b1) @(negedge clk);
    do begin
      @(negedge clk);
      n++;
    end while (period_tick !== 1'b1 && n < 5000);
    n_checks++;
    if (n != expv) begin
      n_fail++;
      $display("FAIL %s: tick spacing actual=%0d expected=%0d", req, n, expv);
    end
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    n_checks++;
    if (pwm_out !== 4'b0000 || period_tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: out=%b tick=%b expected out=0000 tick=0", pwm_out, period_tick);
    end
    rst_n = 1'b1;
    run(10);

    cur_req = "R9 start at boundary";
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd1);
    wr(2'd3, {2'b00, 6'd2});
    wr(2'd2, {2'b01, 2'b10, 2'b11, 2'b00});
    run(60);

    cur_req = "R4 duty write mid-period";
    run(5);
    wr(2'd1, 8'd2);
    run(40);

    cur_req = "R8 polarity";
    wr(2'd2, {2'b10, 2'b01, 2'b11, 2'b10});
    run(40);
    wr(2'd2, {2'b10, 2'b01, 2'b11, 2'b01});
    run(40);

    cur_req = "R7 steering";
    wr(2'd2, {2'b11, 2'b00, 2'b11, 2'b00});
    run(40);
    wr(2'd2, {2'b00, 2'b11, 2'b11, 2'b11});
    run(40);
    wr(2'd2, {2'b01, 2'b00, 2'b11, 2'b00});
    run(40);

    cur_req = "R5 R6 delay commit and dead band";
    wr(2'd3, {2'b00, 6'd5});
    run(20);
    wr(2'd3, {2'b00, 6'd0});
    run(40);
    wr(2'd3, {2'b00, 6'd40});
    run(60);
    wr(2'd3, {2'b00, 6'd1});
    run(40);

    cur_req = "R3 zero and full duty";
    wr(2'd1, 8'd0);
    wr(2'd2, {2'b01, 2'b00, 2'b11, 2'b00});
    run(40);
    wr(2'd1, 8'hff);
    wr(2'd2, {2'b01, 2'b11, 2'b11, 2'b00});
    run(40);

    cur_req = "R2 prescale";
    wr(2'd1, 8'd5);
    wr(2'd2, {2'b01, 2'b00, 2'b11, 2'b00});
    wr(2'd3, {2'b01, 6'd3});
    run(100);
    measure(64, "R2 prescale 4");
    wr(2'd3, {2'b10, 6'd3});
    run(300);
    measure(256, "R2 prescale 16");
    wr(2'd0, 8'd10);
    run(800);
    measure(704, "R1 R2 period 10 prescale 16");

    cur_req = "R1 period";
    wr(2'd3, {2'b00, 6'd3});
    wr(2'd0, 8'd0);
    run(1500);
    measure(4, "R1 period 0");
    wr(2'd0, 8'd7);
    run(80);
    measure(32, "R1 period 7");

    cur_req = "R9 disabled idle";
    wr(2'd2, {2'b01, 2'b00, 2'b00, 2'b00});
    run(50);
    wr(2'd2, {2'b10, 2'b00, 2'b01, 2'b11});
    run(50);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule